// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt requests and tells the processor which one to serve. Each request line is copied every clock into a pending register. Software can also force any source active through a force register. A mask register can hold any source back. Each source has an 8-bit priority byte. Writing a nonzero byte turns the source on, and writing zero turns it off.

A combinational resolver looks at every source that is requesting, turned on and unmasked. It picks the one with the largest priority byte. The winner's priority byte and a vector number are registered and driven to the processor. Software reaches all state through a small synchronous register bus. The bus supports byte and 32-bit accesses, returns read data one cycle after the access, and flags any access to an unmapped offset.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The pending register copies `irq_in` on every clock. A 32-bit read returns bits 63:32 at offset 0x00 and bits 31:0 at offset 0x04. Writes to either offset leave the register unchanged.
- R2: A source takes part in arbitration only when all three hold: its pending or force bit is 1, its priority byte is nonzero, and its mask bit is 0. After reset every mask bit is 1, and the pending and force registers are all zero.
- R3: Source n has a priority byte at offset 0x40+n. A byte access uses data bits 7:0. A 32-bit access at offset 0x40+4m covers sources 4m to 4m+3, with source 4m in bits 31:24. A byte of zero turns the source off, and any nonzero byte turns it on.
- R4: The winner is the taking-part source with the largest priority byte. When several sources share that byte value, the highest source index wins.
- R5: `irq_vector` is 64 plus the winner's index, and `irq_level` is the winner's byte. With no source taking part, `irq_level` is 0 and `irq_vector` is 24.
- R6: `irq_level` and `irq_vector` are registered. They reflect the register state and the pending bits one clock after that state changes.
- R7: The mask register is written as two 32-bit halves: bits 63:32 at offset 0x08 and bits 31:0 at offset 0x0C. Writing one half leaves the other half unchanged.
- R8: The force register is read and written as two 32-bit halves: bits 63:32 at offset 0x10 and bits 31:0 at offset 0x14.
- R9: A byte write to offset 0x1C sets the mask bit numbered by write data bits 5:0. A byte write to offset 0x1D clears that bit. Byte reads of these two offsets return zero without an error. A 32-bit access to them is an error.
- R10: A read of offset 0xE0 (either size) returns the current registered vector in the low bits, with zeros above.
- R11: After reset all priority bytes are zero, `irq_level` is 0 and `irq_vector` is 24.
- R12: An access to any other offset, a byte access to a 32-bit register, or a misaligned 32-bit access is an error. It returns zero data and raises `bus_err` for one cycle, in the same cycle as the read data. It changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| irq_in | input | 64 | Level-sensitive request lines, bit n is source n |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| bus_err | output | 1 | One-cycle error flag, aligned with bus_rdata |
| irq_level | output | 8 | Priority byte of the winning source, 0 when idle |
| irq_vector | output | 8 | Vector of the winning source, 24 when idle |

## Verification
Two things can land in the same clock. One is a software read of the acknowledge offset. The other is a request edge that changes the winner. The bench raises a stronger request in exactly the cycle it issues the 0xE0 read. The read must return the vector registered before the edge, and a later read must return the new winner.

A second overlap is a mask command that changes the winner while other sources stay requesting. After each command, the bench checks both the outputs and the mask read-back.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Register map (byte offsets)
  localparam logic [7:0] OFF_PEND_HI  = 8'h00;
  localparam logic [7:0] OFF_PEND_LO  = 8'h04;
  localparam logic [7:0] OFF_MASK_HI  = 8'h08;
  localparam logic [7:0] OFF_MASK_LO  = 8'h0C;
  localparam logic [7:0] OFF_FORCE_HI = 8'h10;
  localparam logic [7:0] OFF_FORCE_LO = 8'h14;
  localparam logic [7:0] OFF_MSK_SET  = 8'h1C;
  localparam logic [7:0] OFF_MSK_CLR  = 8'h1D;
  localparam logic [7:0] OFF_ACK      = 8'hE0;

  // Upper two address bits selecting the priority byte window 0x40..0x7F
  localparam logic [1:0] LVL_WINDOW   = 2'b01;

  localparam int unsigned DEF_NSRC     = 64;
  localparam int unsigned DEF_LVL_W    = 8;
  localparam int unsigned DEF_VEC_W    = 8;
  localparam int unsigned DEF_VEC_BASE = 64;
  localparam int unsigned DEF_VEC_IDLE = 24;

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC   = DEF_NSRC,
  parameter int unsigned LVL_W  = DEF_LVL_W,
  parameter int unsigned VEC_W  = DEF_VEC_W,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            irq_in,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic                       bus_word,
  input  logic [7:0]                 bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [VEC_W-1:0]           cur_vec,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       bus_err,
  output logic [NSRC-1:0]            pend_o,
  output logic [NSRC-1:0]            frc_o,
  output logic [NSRC-1:0]            mask_o,
  output logic [NSRC-1:0][LVL_W-1:0] lvl_o
);

  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned LPW   = DATA_W / LVL_W;   // priority bytes per word
  localparam int unsigned SUB_W = $clog2(LPW);

  logic [NSRC-1:0]            pend_q, frc_q, frc_d, msk_q, msk_d;
  logic [NSRC-1:0][LVL_W-1:0] lvl_q, lvl_d;
  logic [DATA_W-1:0]          rd_d, rdata_q;
  logic                       err_d, err_q;
  logic                       frc_we, msk_we, lvl_we;

  // Next-state: decode one access per cycle
  always_comb begin
    frc_d  = frc_q;
    msk_d  = msk_q;
    lvl_d  = lvl_q;
    frc_we = 1'b0;
    msk_we = 1'b0;
    lvl_we = 1'b0;
    rd_d   = '0;
    err_d  = 1'b0;
    if (bus_sel) begin
      if (bus_addr[7:6] == LVL_WINDOW) begin
        if (!bus_word) begin
          if (bus_wr) begin
            lvl_d[bus_addr[IDX_W-1:0]] = bus_wdata[LVL_W-1:0];
            lvl_we = 1'b1;
          end else begin
            rd_d = {{(DATA_W-LVL_W){1'b0}}, lvl_q[bus_addr[IDX_W-1:0]]};
          end
        end else if (bus_addr[SUB_W-1:0] == '0) begin
          for (int k = 0; k < LPW; k++) begin
            if (bus_wr)
              lvl_d[{bus_addr[IDX_W-1:SUB_W], SUB_W'(k)}] = bus_wdata[DATA_W-1-LVL_W*k -: LVL_W];
            else
              rd_d[DATA_W-1-LVL_W*k -: LVL_W] = lvl_q[{bus_addr[IDX_W-1:SUB_W], SUB_W'(k)}];
          end
          lvl_we = bus_wr;
        end else begin
          err_d = 1'b1;
        end
      end else begin
        case (bus_addr)
          OFF_PEND_HI: if (!bus_word) err_d = 1'b1;
                       else if (!bus_wr) rd_d = pend_q[NSRC-1 -: DATA_W];
          OFF_PEND_LO: if (!bus_word) err_d = 1'b1;
                       else if (!bus_wr) rd_d = pend_q[DATA_W-1:0];
          OFF_MASK_HI: if (!bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         msk_d[NSRC-1 -: DATA_W] = bus_wdata;
                         msk_we = 1'b1;
                       end else rd_d = msk_q[NSRC-1 -: DATA_W];
          OFF_MASK_LO: if (!bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         msk_d[DATA_W-1:0] = bus_wdata;
                         msk_we = 1'b1;
                       end else rd_d = msk_q[DATA_W-1:0];
          OFF_FORCE_HI: if (!bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         frc_d[NSRC-1 -: DATA_W] = bus_wdata;
                         frc_we = 1'b1;
                       end else rd_d = frc_q[NSRC-1 -: DATA_W];
          OFF_FORCE_LO: if (!bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         frc_d[DATA_W-1:0] = bus_wdata;
                         frc_we = 1'b1;
                       end else rd_d = frc_q[DATA_W-1:0];
          OFF_MSK_SET: if (bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         msk_d[bus_wdata[IDX_W-1:0]] = 1'b1;
                         msk_we = 1'b1;
                       end
          OFF_MSK_CLR: if (bus_word) err_d = 1'b1;
                       else if (bus_wr) begin
                         msk_d[bus_wdata[IDX_W-1:0]] = 1'b0;
                         msk_we = 1'b1;
                       end
          OFF_ACK:     if (!bus_wr) rd_d = {{(DATA_W-VEC_W){1'b0}}, cur_vec};
          default:     err_d = 1'b1;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      frc_q   <= '0;
      msk_q   <= '1;
      lvl_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= irq_in;
      if (frc_we) frc_q <= frc_d;
      if (msk_we) msk_q <= msk_d;
      if (lvl_we) lvl_q <= lvl_d;
      rdata_q <= rd_d;
      err_q   <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign pend_o    = pend_q;
  assign frc_o     = frc_q;
  assign mask_o    = msk_q;
  assign lvl_o     = lvl_q;

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = DEF_NSRC,
  parameter int unsigned LVL_W    = DEF_LVL_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned VEC_BASE = DEF_VEC_BASE,
  parameter int unsigned VEC_IDLE = DEF_VEC_IDLE
) (
  input  logic [NSRC-1:0]            pend,
  input  logic [NSRC-1:0]            frc,
  input  logic [NSRC-1:0]            mask,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl,
  output logic [LVL_W-1:0]           win_lvl,
  output logic [VEC_W-1:0]           win_vec
);

  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]  act;
  logic [IDX_W-1:0] best_idx;
  logic             found;

  // A source is on whenever its priority byte is nonzero
  for (genvar g = 0; g < NSRC; g++) begin : g_act
    assign act[g] = (pend[g] | frc[g]) & (lvl[g] != '0) & ~mask[g];
  end

  // Upward scan with >=: equal levels go to the higher index
  always_comb begin
    win_lvl  = '0;
    best_idx = '0;
    found    = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (act[i] && (lvl[i] >= win_lvl)) begin
        win_lvl  = lvl[i];
        best_idx = IDX_W'(i);
        found    = 1'b1;
      end
    end
    win_vec = found ? (VEC_W'(VEC_BASE) + VEC_W'(best_idx)) : VEC_W'(VEC_IDLE);
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NSRC     = DEF_NSRC,
  parameter int unsigned LVL_W    = DEF_LVL_W,
  parameter int unsigned VEC_W    = DEF_VEC_W,
  parameter int unsigned VEC_BASE = DEF_VEC_BASE,
  parameter int unsigned VEC_IDLE = DEF_VEC_IDLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_word,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             bus_err,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector
);

  logic [1:0]                 rst_sync_q;
  logic                       rst_sync_n;
  logic [NSRC-1:0]            pend_w, frc_w, mask_w;
  logic [NSRC-1:0][LVL_W-1:0] lvl_w;
  logic [LVL_W-1:0]           res_lvl, lvl_q;
  logic [VEC_W-1:0]           res_vec, vec_q;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_prio_regs #(
    .NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W), .DATA_W(32)
  ) regs_i (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_vec(vec_q),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .pend_o(pend_w), .frc_o(frc_w), .mask_o(mask_w), .lvl_o(lvl_w)
  );

  irq_prio_resolver #(
    .NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
  ) res_i (
    .pend(pend_w), .frc(frc_w), .mask(mask_w), .lvl(lvl_w),
    .win_lvl(res_lvl), .win_vec(res_vec)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lvl_q <= '0;
      vec_q <= VEC_W'(VEC_IDLE);
    end else begin
      lvl_q <= res_lvl;
      vec_q <= res_vec;
    end
  end

  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned LVL_W    = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned VEC_IDLE = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic             bus_word,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             bus_err,
  input logic [NSRC-1:0]  mask_w,
  input logic [LVL_W-1:0] irq_level,
  input logic [VEC_W-1:0] irq_vector
);

  localparam int unsigned IDX_W = $clog2(NSRC);

  assert_idle_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) == (irq_vector == VEC_W'(VEC_IDLE)));

  assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE)));

  assert_all_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_w) |=> (irq_level == '0));

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word && bus_addr == 8'h1C)
      |=> mask_w[$past(bus_wdata[IDX_W-1:0])]);

  assert_mask_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_word && bus_addr == 8'h1D)
      |=> !mask_w[$past(bus_wdata[IDX_W-1:0])]);

  assert_err_follows_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel));

  assert_err_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

endmodule

bind irq_prio_ctrl irq_prio_chk #(
  .NSRC(NSRC), .LVL_W(LVL_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
) chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .bus_err(bus_err),
  .mask_w(mask_w), .irq_level(irq_level), .irq_vector(irq_vector)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [63:0] irq_in;
  logic        bus_sel, bus_wr, bus_word;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [7:0]  irq_level;
  logic [7:0]  irq_vector;

  int total = 0;
  int bad   = 0;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks are entered and left just after a falling edge
  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_word = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic word, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic word,
                    output logic [31:0] d, output logic e);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_word = word; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; e = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic unmask_all();
    wr(8'h08, 1'b1, 32'h0);
    wr(8'h0C, 1'b1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    do_reset();
    chk("R11 level after reset", irq_level, 0);
    chk("R11 vector after reset", irq_vector, 24);
    rd(8'h08, 1'b1, d, e); chk("R2 mask hi reset", d, 32'hFFFFFFFF);
    rd(8'h0C, 1'b1, d, e); chk("R2 mask lo reset", d, 32'hFFFFFFFF);
    rd(8'h10, 1'b1, d, e); chk("R2 force reset", d, 0);
    rd(8'h45, 1'b0, d, e); chk("R11 level byte reset", d, 0);
    rd(8'hE0, 1'b1, d, e); chk("R11 ack vector reset", d, 24);
  endtask

  task automatic t_pending();
    logic [31:0] d; logic e;
    do_reset();
    irq_in = (64'd1 << 63) | (64'd1 << 33) | 64'd1;
    settle();
    rd(8'h00, 1'b1, d, e); chk("R1 pending hi", d, 32'h80000002);
    rd(8'h04, 1'b1, d, e); chk("R1 pending lo", d, 32'h00000001);
    wr(8'h04, 1'b1, 32'hFFFFFFFF);
    rd(8'h04, 1'b1, d, e); chk("R1 pending write ignored", d, 32'h00000001);
    chk("R1 pending write no error", e, 0);
    chk("R2 masked and off gives idle", irq_level, 0);
    wr(8'h40, 1'b0, 32'h9);
    settle();
    chk("R2 masked source stays idle", irq_vector, 24);
    unmask_all();
    settle();
    chk("R2 unmasked source level", irq_level, 9);
    chk("R2 unmasked source vector", irq_vector, 64);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic e;
    do_reset();
    irq_in[5] = 1'b1;
    wr(8'h45, 1'b0, 32'h3);
    wr(8'h1D, 1'b0, 32'h5);
    chk("R6 output not yet updated", irq_vector, 24);
    @(negedge clk);
    chk("R6 level one clock later", irq_level, 3);
    chk("R5 vector 64+5", irq_vector, 69);
    rd(8'h45, 1'b0, d, e); chk("R3 level byte readback", d, 3);
    wr(8'h45, 1'b0, 32'h0);
    @(negedge clk);
    chk("R3 zero byte disables level", irq_level, 0);
    chk("R3 zero byte disables vector", irq_vector, 24);
  endtask

  task automatic t_priority();
    do_reset();
    unmask_all();
    wr(8'h4A, 1'b0, 32'h2);
    wr(8'h54, 1'b0, 32'h5);
    wr(8'h5E, 1'b0, 32'h5);
    irq_in = (64'd1 << 10) | (64'd1 << 20) | (64'd1 << 30);
    settle();
    chk("R4 tie goes to higher index", irq_vector, 94);
    chk("R4 tie level", irq_level, 5);
    irq_in[30] = 1'b0;
    settle();
    chk("R4 next highest after drop", irq_vector, 84);
    wr(8'h4A, 1'b0, 32'h7);
    settle();
    chk("R4 raised level wins", irq_vector, 74);
    chk("R4 raised level value", irq_level, 7);
  endtask

  task automatic t_mask();
    logic [31:0] d; logic e;
    do_reset();
    unmask_all();
    wr(8'h4A, 1'b0, 32'h7);
    wr(8'h54, 1'b0, 32'h5);
    irq_in = (64'd1 << 10) | (64'd1 << 20);
    settle();
    chk("R9 setup winner", irq_vector, 74);
    wr(8'h1C, 1'b0, 32'h4A);  // low 6 bits = 10
    settle();
    chk("R9 set command masks source 10", irq_vector, 84);
    rd(8'h0C, 1'b1, d, e); chk("R9 mask bit 10 readback", d, 32'h00000400);
    rd(8'h1C, 1'b0, d, e); chk("R9 command reads zero", d, 0);
    chk("R9 command read no error", e, 0);
    wr(8'h1D, 1'b0, 32'h0A);
    settle();
    chk("R9 clear command unmasks source 10", irq_vector, 74);
    wr(8'h08, 1'b1, 32'hFFFF0000);
    rd(8'h0C, 1'b1, d, e); chk("R7 low half kept", d, 0);
    rd(8'h08, 1'b1, d, e); chk("R7 high half written", d, 32'hFFFF0000);
    wr(8'h0C, 1'b1, 32'h00000400);
    rd(8'h08, 1'b1, d, e); chk("R7 high half kept", d, 32'hFFFF0000);
    settle();
    chk("R7 low half write masks 10", irq_vector, 84);
  endtask

  task automatic t_force();
    logic [31:0] d; logic e;
    do_reset();
    unmask_all();
    wr(8'h60, 1'b1, 32'h04000000);
    wr(8'h10, 1'b1, 32'h00000001);
    settle();
    chk("R8 forced source level", irq_level, 4);
    chk("R8 forced source vector", irq_vector, 96);
    rd(8'h10, 1'b1, d, e); chk("R8 force hi readback", d, 1);
    rd(8'h14, 1'b1, d, e); chk("R8 force lo readback", d, 0);
    rd(8'h60, 1'b0, d, e); chk("R3 word write MSB byte is lowest source", d, 4);
    rd(8'h61, 1'b0, d, e); chk("R3 word write next byte", d, 0);
    rd(8'h60, 1'b1, d, e); chk("R3 word read packing", d, 32'h04000000);
    wr(8'h7F, 1'b0, 32'h1);
    irq_in[63] = 1'b1;
    wr(8'h10, 1'b1, 32'h0);
    settle();
    chk("R5 top source vector", irq_vector, 127);
    chk("R5 top source level", irq_level, 1);
  endtask

  task automatic t_ack();
    logic [31:0] d; logic e;
    do_reset();
    unmask_all();
    wr(8'h47, 1'b0, 32'h2);
    wr(8'h49, 1'b0, 32'h6);
    irq_in[7] = 1'b1;
    settle();
    rd(8'hE0, 1'b1, d, e); chk("R10 ack word read", d, 71);
    rd(8'hE0, 1'b0, d, e); chk("R10 ack byte read", d, 71);
    irq_in[9] = 1'b1;                 // same cycle as the read below
    rd(8'hE0, 1'b1, d, e); chk("R10 ack read in winner-change cycle", d, 71);
    settle();
    rd(8'hE0, 1'b1, d, e); chk("R10 ack read after change", d, 73);
  endtask

  task automatic t_err();
    logic [31:0] d; logic e;
    do_reset();
    rd(8'h30, 1'b1, d, e);
    chk("R12 undefined read data", d, 0);
    chk("R12 undefined read error", e, 1);
    @(negedge clk);
    chk("R12 error lasts one cycle", bus_err, 0);
    rd(8'h08, 1'b0, d, e); chk("R12 byte access to word reg", e, 1);
    rd(8'h42, 1'b1, d, e); chk("R12 misaligned word", e, 1);
    rd(8'h1C, 1'b1, d, e); chk("R9 word access to command", e, 1);
    wr(8'h30, 1'b1, 32'h0);
    wr(8'h0A, 1'b1, 32'h0);
    rd(8'h08, 1'b1, d, e);
    chk("R12 bad write leaves mask", d, 32'hFFFFFFFF);
    chk("R12 good read no error", e, 0);
    rd(8'h0C, 1'b1, d, e);
    chk("R12 bad write leaves mask lo", d, 32'hFFFFFFFF);
  endtask

  initial begin
    t_reset();
    t_pending();
    t_enable();
    t_priority();
    t_mask();
    t_force();
    t_ack();
    t_err();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule